// File: doc/BRIEF.md
# Block Memory Copy and Compare Sequencer

This block runs the string-style memory operations of a small 8-bit processor: it moves a run of bytes from one address to another, or scans a run of bytes for a value equal to an 8-bit accumulator. It keeps a 16-bit source pointer, a 16-bit destination pointer, a 16-bit byte count and the 8-bit accumulator. It drives a byte-wide synchronous memory port. On a read, the data is returned in the cycle after the address is presented.

The surrounding core places the pointer, count and accumulator values on the load inputs and sets a 3-bit command. It then pulses the start input for one clock. The block captures the values and performs either one byte step or a repeated run. It holds busy high throughout and pulses done for one clock when it finishes. After done, the updated pointers, the count, a match flag and a count-nonzero flag are available on the outputs.

Top module: `blockMover`

## Requirements
- R1: After reset, busy, done, the match flag, the count-nonzero flag and the memory enable are low, and the pointer and count outputs read zero.
- R2: The command is `cmdCode[2]`=compare, `cmdCode[1]`=repeat and `cmdCode[0]`=backward. A forward single copy (code 0) reads the byte at the source pointer and writes it to the destination pointer. It then adds one to both pointers and subtracts one from the count.
- R3: A backward single copy (code 1) moves the byte in the same way, but subtracts one from the source pointer, the destination pointer and the count.
- R4: A repeated copy (code 2 forward, code 3 backward) repeats the single copy step until the count reaches zero. Each byte is read before it is written, so an overlapping run behaves as a sequence of single steps.
- R5: A forward single compare (code 4) reads the byte at the source pointer and compares it with the accumulator. It adds one to the source pointer and subtracts one from the count. It never writes memory and leaves the destination pointer unchanged.
- R6: A backward single compare (code 5) behaves like R5, but subtracts one from the source pointer.
- R7: A repeated compare (code 6 or 7) stops either when the count reaches zero or after the first byte equal to the accumulator, whichever comes first. When the operation ends, the match flag shows whether the last byte compared was equal. After any copy, the match flag is low.
- R8: The count-nonzero output is high exactly when the count left after the operation is not zero.
- R9: Each byte step takes exactly two clocks. The first clock is a read at the source pointer. The second clock is a write at the destination pointer for a copy, or a clock with no memory access for a compare. Busy stays high for twice the number of steps. Done is high for exactly one clock, in the first cycle in which busy is low.
- R10: All pointer and count arithmetic wraps modulo 2^16. A start with a count of zero decrements the count to 0xFFFF before testing it, so a repeated operation started from zero keeps running.
- R11: A start pulse while busy is high has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts an operation when the block is idle |
| cmdCode | input | 3 | Command: bit 2 compare, bit 1 repeat, bit 0 backward |
| srcIn | input | 16 | Source pointer value captured at start |
| dstIn | input | 16 | Destination pointer value captured at start |
| cntIn | input | 16 | Byte count captured at start |
| accIn | input | 8 | Accumulator value captured at start |
| memAddr | output | 16 | Memory address |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Write strobe (valid while memEn is high) |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, returned one clock after a read |
| srcOut | output | 16 | Current source pointer |
| dstOut | output | 16 | Current destination pointer |
| cntOut | output | 16 | Current count |
| matchFlag | output | 1 | Last compared byte was equal to the accumulator |
| cntNonZero | output | 1 | Count is not zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |

## Verification
The hardest case to reach is a repeated compare that starts from a count of zero and ends early on a match, because a run with no match would take 65536 steps. The bench sets the accumulator to a byte known to lie a few positions ahead of the source pointer, so the run stops after a few steps with the count wrapped near 0xFFFF. The second hard case is a start pulse in the middle of a run. The bench raises start, with different values on the load inputs, in the middle of a repeated copy. It then checks that the result matches the model of the original command.

// File: rtl/blockMoverPkg.sv
package blockMoverPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_XFER = 2'd2
  } moverState_t;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadRegs;  // capture the load inputs
    logic rdCycle;   // read at the source pointer
    logic wrCycle;   // write at the destination pointer
    logic stepEn;    // update pointers and count at the end of a step
    logic cmpMode;   // current command is a compare
    logic dirBack;   // current command steps downward
  } ctrlStrobes_t;

endpackage

// File: rtl/blockMoverCtrl.sv
module blockMoverCtrl
  import blockMoverPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic [2:0]   cmdCode,
  input  logic         byteHit,
  input  logic         cntLast,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         done
);

  moverState_t stateQ;
  logic cmpQ, rptQ, backQ;
  logic doneQ;
  logic keepGoing;

  // Repeat until the count is about to reach zero, or until a compare hits
  assign keepGoing = rptQ && !cntLast && !(cmpQ && byteHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cmpQ   <= 1'b0;
      rptQ   <= 1'b0;
      backQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: if (startPulse) begin
          cmpQ   <= cmdCode[2];
          rptQ   <= cmdCode[1];
          backQ  <= cmdCode[0];
          stateQ <= ST_READ;
        end
        ST_READ: stateQ <= ST_XFER;
        ST_XFER: begin
          if (keepGoing) stateQ <= ST_READ;
          else begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadRegs = (stateQ == ST_IDLE) && startPulse;
    strb.rdCycle  = (stateQ == ST_READ);
    strb.wrCycle  = (stateQ == ST_XFER) && !cmpQ;
    strb.stepEn   = (stateQ == ST_XFER);
    strb.cmpMode  = cmpQ;
    strb.dirBack  = backQ;
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_READ_THEN_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_READ) |=> (stateQ == ST_XFER)); // R9
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse) |=> ($stable(cmpQ) && $stable(rptQ) && $stable(backQ))); // R11
  AST_STOP_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_XFER) && cmpQ && byteHit) |=> (stateQ == ST_IDLE)); // R7

endmodule

// File: rtl/blockMoverPath.sv
module blockMoverPath
  import blockMoverPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strb,
  input  logic [AW-1:0] srcIn,
  input  logic [AW-1:0] dstIn,
  input  logic [AW-1:0] cntIn,
  input  logic [DW-1:0] accIn,
  output logic [AW-1:0] memAddr,
  output logic          memEn,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] srcOut,
  output logic [AW-1:0] dstOut,
  output logic [AW-1:0] cntOut,
  output logic          matchFlag,
  output logic          cntNonZero,
  output logic          byteHit,
  output logic          cntLast
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] srcReg, dstReg, cntReg;
  logic [DW-1:0] accReg;
  logic          matchReg;
  logic [AW-1:0] srcStep, dstStep;

  assign srcStep = strb.dirBack ? (srcReg - ONE) : (srcReg + ONE);
  assign dstStep = strb.dirBack ? (dstReg - ONE) : (dstReg + ONE);

  // Read data returns in the second cycle of a step; it feeds both paths
  assign byteHit  = (memRdata == accReg);
  assign cntLast  = (cntReg == ONE);
  assign memEn    = strb.rdCycle | strb.wrCycle;
  assign memWe    = strb.wrCycle;
  assign memAddr  = strb.wrCycle ? dstReg : srcReg;
  assign memWdata = memRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg   <= '0;
      dstReg   <= '0;
      cntReg   <= '0;
      accReg   <= '0;
      matchReg <= 1'b0;
    end else if (strb.loadRegs) begin
      srcReg   <= srcIn;
      dstReg   <= dstIn;
      cntReg   <= cntIn;
      accReg   <= accIn;
      matchReg <= 1'b0;
    end else if (strb.stepEn) begin
      srcReg <= srcStep;
      cntReg <= cntReg - ONE;
      if (strb.cmpMode) matchReg <= byteHit;
      else              dstReg   <= dstStep;
    end
  end

  assign srcOut     = srcReg;
  assign dstOut     = dstReg;
  assign cntOut     = cntReg;
  assign matchFlag  = matchReg;
  assign cntNonZero = (cntReg != '0);

  AST_SRC_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && !strb.dirBack) |=> (srcReg == $past(srcReg) + ONE)); // R2
  AST_SRC_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && strb.dirBack) |=> (srcReg == $past(srcReg) - ONE)); // R3
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepEn |=> (cntReg == $past(cntReg) - ONE)); // R4
  AST_DST_HELD_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && strb.cmpMode) |=> $stable(dstReg)); // R5
  AST_NO_WRITE_CMP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !strb.cmpMode); // R5
  AST_MATCH_FROM_CMP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> $past(strb.cmpMode)); // R7

endmodule

// File: rtl/blockMover.sv
module blockMover
  import blockMoverPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic [2:0]    cmdCode,
  input  logic [AW-1:0] srcIn,
  input  logic [AW-1:0] dstIn,
  input  logic [AW-1:0] cntIn,
  input  logic [DW-1:0] accIn,
  output logic [AW-1:0] memAddr,
  output logic          memEn,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] srcOut,
  output logic [AW-1:0] dstOut,
  output logic [AW-1:0] cntOut,
  output logic          matchFlag,
  output logic          cntNonZero,
  output logic          busy,
  output logic          done
);

  ctrlStrobes_t strb;
  logic byteHit, cntLast;

  blockMoverCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmdCode(cmdCode),
    .byteHit(byteHit), .cntLast(cntLast), .strb(strb), .busy(busy), .done(done)
  );

  blockMoverPath #(.AW(AW), .DW(DW)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcIn(srcIn), .dstIn(dstIn), .cntIn(cntIn), .accIn(accIn),
    .memAddr(memAddr), .memEn(memEn), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .srcOut(srcOut), .dstOut(dstOut), .cntOut(cntOut),
    .matchFlag(matchFlag), .cntNonZero(cntNonZero),
    .byteHit(byteHit), .cntLast(cntLast)
  );

endmodule

// File: tb/sim_blockMover.sv
`timescale 1ns/1ps
module sim_blockMover;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [2:0]  cmdCode = '0;
  logic [15:0] srcIn = '0, dstIn = '0, cntIn = '0;
  logic [7:0]  accIn = '0;
  logic [15:0] memAddr;
  logic        memEn, memWe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;
  logic [15:0] srcOut, dstOut, cntOut;
  logic        matchFlag, cntNonZero, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blockMover u0 (.*);

  // Synchronous memory, low 10 address bits used
  logic [7:0] mem [1024];
  logic [7:0] expMem [1024];
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 5);
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr[9:0]] <= memWdata;
      else       memRdata <= mem[memAddr[9:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] stepPtr(input logic [15:0] p, input bit back);
    return back ? p - 16'd1 : p + 16'd1;
  endfunction

  // Reference model: updates expMem, returns expected registers and step count
  task automatic model(input logic [2:0] cmd, input logic [15:0] s, d, c,
                       input logic [7:0] a, output logic [15:0] es, ed, ec,
                       output bit em, output int steps);
    bit hit = 0;
    logic [7:0] b;
    es = s; ed = d; ec = c; steps = 0;
    do begin
      b = expMem[es[9:0]];
      if (!cmd[2]) begin
        expMem[ed[9:0]] = b;
        ed = stepPtr(ed, cmd[0]);
      end else hit = (b == a);
      es = stepPtr(es, cmd[0]);
      ec = ec - 16'd1;
      steps++;
    end while (cmd[1] && ec != 16'd0 && !(cmd[2] && hit));
    em = cmd[2] ? hit : 1'b0;
  endtask

  task automatic runOp(input logic [2:0] cmd, input logic [15:0] s, d, c,
                       input logic [7:0] a, input string req, input bit poke);
    logic [15:0] es, ed, ec;
    bit em;
    int steps, cyc, bad;
    model(cmd, s, d, c, a, es, ed, ec, em, steps);
    @(negedge clk);
    cmdCode = cmd; srcIn = s; dstIn = d; cntIn = c; accIn = a; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cyc = 0;
    while (busy && cyc < 300) begin
      if (poke && cyc == 3) begin
        startPulse = 1'b1; cmdCode = ~cmd; srcIn = ~s; dstIn = ~d; cntIn = 16'd2; accIn = ~a;
      end else startPulse = 1'b0;
      cyc++;
      @(negedge clk);
    end
    startPulse = 1'b0;
    chk(cyc < 300, "R9", "watchdog", cyc, 2 * steps);
    chk(cyc == 2 * steps, "R9", "busy cycles", cyc, 2 * steps);
    chk(done == 1'b1, "R9", "done after busy", done, 1);
    chk(srcOut == es, req, "source", srcOut, es);
    chk(dstOut == ed, req, "destination", dstOut, ed);
    chk(cntOut == ec, req, "count", cntOut, ec);
    chk(matchFlag == em, "R7", "match flag", matchFlag, em);
    chk(cntNonZero == (ec != 0), "R8", "count nonzero", cntNonZero, ec != 0);
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expMem[i]) bad++;
    chk(bad == 0, req, "memory mismatches", bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one clock", done, 0);
    if (poke) chk(busy == 1'b0, "R11", "no restart from mid-run start", busy, 0);
  endtask

  // Global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [15:0] s;
    int c;
    bit found;
    process::self().srandom(32'd1234);
    for (int i = 0; i < 1024; i++) expMem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !matchFlag && !cntNonZero && !memEn, "R1", "reset strobes",
        {busy, done, matchFlag, cntNonZero, memEn}, 0);
    chk(srcOut == 0 && dstOut == 0 && cntOut == 0, "R1", "reset registers",
        srcOut ^ dstOut ^ cntOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(3'd0, 16'h0010, 16'h0200, 16'd5, 8'h00, "R2", 0);
    runOp(3'd1, 16'h0030, 16'h0280, 16'd1, 8'h00, "R3", 0);
    runOp(3'd2, 16'h0040, 16'h0300, 16'd8, 8'h00, "R4", 0);
    runOp(3'd3, 16'h0060, 16'h0064, 16'd6, 8'h00, "R4", 0);  // overlapping, downward
    runOp(3'd2, 16'h0070, 16'h0072, 16'd6, 8'h00, "R4", 0);  // overlapping, upward
    runOp(3'd4, 16'h0100, 16'h1234, 16'd4, expMem[10'h100], "R5", 0);
    runOp(3'd5, 16'h0000, 16'h4321, 16'd3, 8'h00, "R6", 0);  // wraps to FFFF (R10)
    runOp(3'd6, 16'h0120, 16'h0000, 16'd10, expMem[10'h123], "R7", 0);
    // Repeated compare with no byte equal to the accumulator
    a = 0;
    found = 0;
    for (int v = 0; v < 256 && !found; v++) begin
      bit inRun = 0;
      for (int k = 0; k < 6; k++) if (expMem[10'h140 + k] == 8'(v)) inRun = 1;
      if (!inRun) begin a = 8'(v); found = 1; end
    end
    runOp(3'd7, 16'h0145, 16'h0000, 16'd6, a, "R7", 0);
    runOp(3'd0, 16'hFFFF, 16'h0150, 16'd0, 8'h00, "R10", 0);  // count 0 -> FFFF
    runOp(3'd6, 16'h0160, 16'h0000, 16'd0, expMem[10'h162], "R10", 0);
    runOp(3'd2, 16'h0180, 16'h0380, 16'd10, 8'h00, "R11", 1);

    // Constrained random operations
    for (int n = 0; n < 40; n++) begin
      s = 16'($urandom);
      c = 1 + ($urandom % 24);
      a = ($urandom % 2) ? expMem[10'(s + 16'($urandom % c))] : 8'($urandom);
      runOp(3'($urandom), s, 16'($urandom), 16'(c), a, "R4", 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule